// File: doc/BRIEF.md
# Ordered Infoframe Packet Scheduler

This block decides which data-island packets a display transmitter sends during each vertical blanking interval. Software fills two 32-bit slot registers with an ordered list of 4-bit packet-type codes. Each vertical-blanking start pulse begins a walk through the list. For every slot that holds a valid packet type, the scheduler asks a downstream packet formatter for that packet and waits for the formatter to report completion. It then moves on to the next slot.

The walk ends at the first end-of-list code, or after the final slot of the second register. Reserved codes are passed over without a request and are recorded in a sticky error flag. A blanking pulse that arrives while a walk is still running restarts the list from its first slot and sets a sticky overrun flag.

Top module: `pkt_slot_sched`

## Requirements
- R1: Slot n of a register holds bits 4n+3:4n, and slots are visited in ascending order. All eight slots of register 0 (write select 0) come before the slots of register 1 (write select 1), so the list has 16 positions.
- R2: For a slot holding code 0, 1, 2, 3 or 5, exactly one request is raised. `pktReq` is high with that code on `pktType`, and it stays high until the cycle in which `pktDone` is sampled high. It falls on the following cycle.
- R3: Code 15 ends the walk. No slot after it is requested during that blanking interval.
- R4: After reset, register 0 holds 0x0000F321 and register 1 holds 0. This is the list general control (1), AVI (2), audio infoframe (3), end (15).
- R5: If no slot holds code 15, the walk stops after the last slot of register 1, having visited all 16 positions.
- R6: Codes 4 and 6 to 14 are skipped without a request. Each one sets `badCodeFlag`, which stays set until reset.
- R7: A `vblankStart` pulse while `busy` is high drops any pending request and restarts the walk at slot 0. It also sets `overrunFlag`, which stays set until reset. A pulse while idle does not set `overrunFlag`.
- R8: While reset is asserted and just after it, `pktReq`, `busy`, `overrunFlag` and `badCodeFlag` are all low.
- R9: While a request is pending and no new blanking pulse arrives, `pktType` does not change.
- R10: A code 0 (null packet) placed before the end marker still produces a request with type 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Slot register write strobe |
| wrSel | input | 1 | Slot register select (0 or 1) |
| wrData | input | 32 | Slot register write data |
| vblankStart | input | 1 | One-cycle pulse at the start of vertical blanking |
| pktReq | output | 1 | Packet request to the formatter |
| pktType | output | 4 | Packet-type code of the pending request |
| pktDone | input | 1 | Formatter completion handshake |
| busy | output | 1 | A walk is in progress |
| overrunFlag | output | 1 | Sticky: blanking pulse arrived during a walk |
| badCodeFlag | output | 1 | Sticky: reserved code encountered |

## Verification
The hardest case to reach is the overrun restart. It needs a second blanking pulse while a request is still outstanding, which a prompt formatter never allows. The bench formatter model therefore has a hold switch that withholds `pktDone`. The stimulus raises a request, holds it for several cycles while checking that the type stays put, and then fires the second pulse. After release, the full list must be seen again from its first slot. The other list shapes are covered by a table of register images: a list with no end marker that spans both registers, reserved codes mixed with valid ones, and an end marker in the first slot.

// File: rtl/pkt_sched_pkg.sv
package pkt_sched_pkg;

  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] PT_NULL  = 4'd0;
  localparam logic [CODE_W-1:0] PT_GCTL  = 4'd1;
  localparam logic [CODE_W-1:0] PT_AVI   = 4'd2;
  localparam logic [CODE_W-1:0] PT_AUDIO = 4'd3;
  localparam logic [CODE_W-1:0] PT_SPD   = 4'd5;
  localparam logic [CODE_W-1:0] PT_END   = 4'd15;

  // strobes from control to datapath
  typedef struct packed {
    logic clrIdx;
    logic incIdx;
    logic loadType;
    logic setOvr;
    logic setBad;
  } schedCtl_t;

  function automatic logic isSendable(input logic [CODE_W-1:0] code);
    return (code == PT_NULL) || (code == PT_GCTL) || (code == PT_AVI) ||
           (code == PT_AUDIO) || (code == PT_SPD);
  endfunction

  function automatic logic isEnd(input logic [CODE_W-1:0] code);
    return code == PT_END;
  endfunction

endpackage

// File: rtl/pkt_sched_dp.sv
module pkt_sched_dp
  import pkt_sched_pkg::*;
#(
  parameter int SLOTS_PER_REG = 8,
  parameter int NUM_REGS      = 2,
  parameter int DATA_W        = SLOTS_PER_REG * CODE_W,
  parameter int REG_SEL_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  parameter int IDX_W         = $clog2(SLOTS_PER_REG * NUM_REGS),
  parameter logic [NUM_REGS*DATA_W-1:0] DEF_ALL = {{(NUM_REGS*DATA_W-16){1'b0}}, 16'hF321}
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [REG_SEL_W-1:0] wrSel,
  input  logic [DATA_W-1:0]    wrData,
  input  schedCtl_t            ctl,
  output logic [CODE_W-1:0]    curCode,
  output logic                 lastSlot,
  output logic [CODE_W-1:0]    typeQ,
  output logic                 overrunFlag,
  output logic                 badCodeFlag
);

  localparam int TOTAL = SLOTS_PER_REG * NUM_REGS;

  logic [NUM_REGS-1:0][DATA_W-1:0] slotRegs;
  logic [CODE_W-1:0]               slotCode [TOTAL];
  logic [IDX_W-1:0]                slotIdx;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotRegs[r] <= DEF_ALL[r*DATA_W +: DATA_W];
      end else if (wrEn && (wrSel == REG_SEL_W'(r))) begin
        slotRegs[r] <= wrData;
      end
    end
    for (genvar s = 0; s < SLOTS_PER_REG; s++) begin : g_slot
      assign slotCode[r*SLOTS_PER_REG + s] = slotRegs[r][s*CODE_W +: CODE_W];
    end
  end

  assign curCode  = slotCode[slotIdx];
  assign lastSlot = (slotIdx == IDX_W'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotIdx     <= '0;
      typeQ       <= '0;
      overrunFlag <= 1'b0;
      badCodeFlag <= 1'b0;
    end else begin
      if (ctl.clrIdx)        slotIdx <= '0;
      else if (ctl.incIdx)   slotIdx <= slotIdx + 1'b1;
      if (ctl.loadType)      typeQ <= curCode;
      if (ctl.setOvr)        overrunFlag <= 1'b1;
      if (ctl.setBad)        badCodeFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/pkt_sched_ctl.sv
module pkt_sched_ctl
  import pkt_sched_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              vblankStart,
  input  logic              pktDone,
  input  logic [CODE_W-1:0] curCode,
  input  logic              lastSlot,
  output schedCtl_t         ctl,
  output logic              pktReq,
  output logic              busy
);

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_WAIT} state_t;

  state_t state, stateNxt;

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    if (vblankStart) begin
      ctl.clrIdx = 1'b1;
      ctl.setOvr = (state != S_IDLE);
      stateNxt   = S_LOOK;
    end else begin
      unique case (state)
        S_LOOK: begin
          if (isEnd(curCode)) begin
            stateNxt = S_IDLE;
          end else if (isSendable(curCode)) begin
            ctl.loadType = 1'b1;
            stateNxt     = S_WAIT;
          end else begin
            ctl.setBad = 1'b1;
            if (lastSlot) stateNxt = S_IDLE;
            else          ctl.incIdx = 1'b1;
          end
        end
        S_WAIT: begin
          if (pktDone) begin
            if (lastSlot) begin
              stateNxt = S_IDLE;
            end else begin
              ctl.incIdx = 1'b1;
              stateNxt   = S_LOOK;
            end
          end
        end
        default: stateNxt = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  assign pktReq = (state == S_WAIT);
  assign busy   = (state != S_IDLE);

endmodule

// File: rtl/pkt_slot_sched.sv
module pkt_slot_sched
  import pkt_sched_pkg::*;
#(
  parameter int SLOTS_PER_REG = 8,
  parameter int NUM_REGS      = 2,
  parameter int DATA_W        = SLOTS_PER_REG * CODE_W,
  parameter int REG_SEL_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [REG_SEL_W-1:0] wrSel,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 vblankStart,
  output logic                 pktReq,
  output logic [CODE_W-1:0]    pktType,
  input  logic                 pktDone,
  output logic                 busy,
  output logic                 overrunFlag,
  output logic                 badCodeFlag
);

  localparam int IDX_W = $clog2(SLOTS_PER_REG * NUM_REGS);

  schedCtl_t         ctl;
  logic [CODE_W-1:0] curCode;
  logic              lastSlot;

  pkt_sched_dp #(
    .SLOTS_PER_REG(SLOTS_PER_REG),
    .NUM_REGS     (NUM_REGS),
    .DATA_W       (DATA_W),
    .REG_SEL_W    (REG_SEL_W),
    .IDX_W        (IDX_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .wrData     (wrData),
    .ctl        (ctl),
    .curCode    (curCode),
    .lastSlot   (lastSlot),
    .typeQ      (pktType),
    .overrunFlag(overrunFlag),
    .badCodeFlag(badCodeFlag)
  );

  pkt_sched_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .vblankStart(vblankStart),
    .pktDone    (pktDone),
    .curCode    (curCode),
    .lastSlot   (lastSlot),
    .ctl        (ctl),
    .pktReq     (pktReq),
    .busy       (busy)
  );

endmodule

// File: rtl/pkt_slot_sched_chk.sv
module pkt_slot_sched_chk (
  input logic       clk,
  input logic       rstN,
  input logic       vblankStart,
  input logic       pktReq,
  input logic [3:0] pktType,
  input logic       pktDone,
  input logic       busy,
  input logic       overrunFlag,
  input logic       badCodeFlag
);

  a_r9_type_stable: assert property (@(posedge clk) disable iff (!rstN)
    (pktReq && !pktDone && !vblankStart) |=> (pktReq && $stable(pktType)));

  a_r2_req_drops: assert property (@(posedge clk) disable iff (!rstN)
    (pktReq && pktDone) |=> !pktReq);

  a_r6_no_reserved_req: assert property (@(posedge clk) disable iff (!rstN)
    pktReq |-> (pktType inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd5}));

  a_r6_bad_sticky: assert property (@(posedge clk) disable iff (!rstN)
    badCodeFlag |=> badCodeFlag);

  a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrunFlag |=> overrunFlag);

  a_r7_ovr_set: assert property (@(posedge clk) disable iff (!rstN)
    (busy && vblankStart) |=> overrunFlag);

  a_r7_restart_drops_req: assert property (@(posedge clk) disable iff (!rstN)
    vblankStart |=> (busy && !pktReq));

  a_r8_idle_no_req: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !pktReq);

endmodule

bind pkt_slot_sched pkt_slot_sched_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .vblankStart(vblankStart),
  .pktReq     (pktReq),
  .pktType    (pktType),
  .pktDone    (pktDone),
  .busy       (busy),
  .overrunFlag(overrunFlag),
  .badCodeFlag(badCodeFlag)
);

// File: tb/sim_pkt_slot_sched.sv
module sim_pkt_slot_sched;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [0:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic        vblankStart = 1'b0;
  logic        pktReq;
  logic [3:0]  pktType;
  logic        pktDone = 1'b0;
  logic        busy;
  logic        overrunFlag;
  logic        badCodeFlag;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // formatter model state
  logic        hold = 1'b0;
  int          recCnt = 0;
  logic [63:0] recSeq = '0;

  pkt_slot_sched u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .vblankStart(vblankStart), .pktReq(pktReq), .pktType(pktType),
    .pktDone(pktDone), .busy(busy), .overrunFlag(overrunFlag),
    .badCodeFlag(badCodeFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [31:0] r0;
    logic [31:0] r1;
    logic [4:0]  cnt;
    logic [63:0] seq;
    logic        bad;
  } vec_t;

  // R1 R2 R3 R5 R6 R10 list shapes; seq holds first request in low nibble
  localparam vec_t VECS [7] = '{
    '{32'h0000F321, 32'h00000000, 5'd3,  64'h321,              1'b0}, // R2 R3
    '{32'h0000F020, 32'h00000000, 5'd3,  64'h020,              1'b0}, // R10
    '{32'h55555555, 32'h11111111, 5'd16, 64'h1111111155555555, 1'b0}, // R5 R1
    '{32'h000F4E52, 32'h00000000, 5'd2,  64'h52,               1'b1}, // R6
    '{32'h0000000F, 32'h12345321, 5'd0,  64'h0,                1'b0}, // R3
    '{32'h21212121, 32'hFFFFF035, 5'd11, 64'h0000003521212121, 1'b0}, // R1
    '{32'h0000F6E4, 32'h00000000, 5'd0,  64'h0,                1'b1}  // R6
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic writeReg(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseVblank();
    @(negedge clk);
    vblankStart = 1'b1;
    @(negedge clk);
    vblankStart = 1'b0;
  endtask

  task automatic waitIdle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  // formatter: one done per request, unless held
  initial begin
    forever begin
      @(negedge clk);
      if (pktDone) begin
        pktDone = 1'b0;
      end else if (pktReq && !hold) begin
        if (recCnt < 16) recSeq[recCnt*4 +: 4] = pktType;
        recCnt++;
        pktDone = 1'b1;
      end
    end
  end

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
        finishRun();
      end
    end
  end

  initial begin
    // R8: reset state
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(!pktReq && !busy && !overrunFlag && !badCodeFlag, "R8 in reset",
        {pktReq, busy, overrunFlag, badCodeFlag}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!pktReq && !busy && !overrunFlag && !badCodeFlag, "R8 after reset",
        {pktReq, busy, overrunFlag, badCodeFlag}, 0);

    // R4: default list with no writes
    recCnt = 0; recSeq = '0;
    pulseVblank();
    waitIdle();
    chk(recCnt == 3, "R4 default count", recCnt, 3);
    chk(recSeq == 64'h321, "R4 default order", recSeq, 64'h321);

    // table walk
    for (int i = 0; i < 7; i++) begin
      doReset();
      writeReg(1'b0, VECS[i].r0);
      writeReg(1'b1, VECS[i].r1);
      recCnt = 0; recSeq = '0;
      pulseVblank();
      waitIdle();
      chk(recCnt == int'(VECS[i].cnt), $sformatf("R2 R3 R5 vec%0d count", i),
          recCnt, VECS[i].cnt);
      chk(recSeq == VECS[i].seq, $sformatf("R1 R10 vec%0d order", i),
          recSeq, VECS[i].seq);
      chk(badCodeFlag == VECS[i].bad, $sformatf("R6 vec%0d bad flag", i),
          badCodeFlag, VECS[i].bad);
      chk(!overrunFlag, $sformatf("R7 vec%0d idle pulse no overrun", i),
          overrunFlag, 0);
    end

    // R6: flag persists across a later clean walk
    writeReg(1'b0, 32'h0000F321);
    recCnt = 0; recSeq = '0;
    pulseVblank();
    waitIdle();
    chk(badCodeFlag && recSeq == 64'h321, "R6 sticky after clean walk",
        {badCodeFlag, recSeq[11:0]}, {1'b1, 12'h321});

    // R7 + R9: overrun restart with held formatter
    doReset();
    @(posedge clk); #1 hold = 1'b1;
    recCnt = 0; recSeq = '0;
    pulseVblank();
    while (!pktReq) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(pktReq && pktType == 4'd1, "R9 type held while pending",
        {pktReq, pktType}, {1'b1, 4'd1});
    chk(!overrunFlag, "R7 no overrun before second pulse", overrunFlag, 0);
    pulseVblank();
    chk(overrunFlag, "R7 overrun set", overrunFlag, 1);
    chk(!pktReq && busy, "R7 pending request dropped", {pktReq, busy}, 2'b01);
    @(posedge clk); #1 hold = 1'b0;
    waitIdle();
    chk(recCnt == 3 && recSeq == 64'h321, "R7 restart from slot 0",
        recSeq, 64'h321);
    chk(overrunFlag, "R7 overrun sticky", overrunFlag, 1);

    finishRun();
  end

endmodule